// File: doc/BRIEF.md
# Counter-Ramp Conversion Sequencer

This block is the digital half of a staircase analog-to-digital converter. A start request clears a binary counter and opens its clock gate. The counter drives the code of an external DAC, so the DAC level climbs one LSB per clock. An external comparator rises once that level reaches the held input sample. The comparator's trip then closes the gate, and the code at which it tripped is stored as the conversion result, with a one-cycle done pulse.

The comparator signal is asynchronous to the sequencer, so it passes through a short flop chain. While the chain resolves, the counter keeps running for a known number of extra cycles. The sequencer subtracts that overshoot when it stores the result, and it then reloads the counter with the result so the DAC settles on the converted code. If the ramp reaches the all-ones code without a trip, the conversion ends with the full-scale code and an overrange flag. Conversion time depends on the data: a result of code C always takes C plus three cycles from the start edge to the done edge.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: During and after reset, busy, done and overrange are 0, and both the result and the DAC code are 0.
- R2: A start request seen while idle makes busy 1 and the DAC code 0 in the following cycle.
- R3: While busy, the DAC code equals the number of clock edges since the start edge, and it holds at the all-ones code once it gets there.
- R4: The result equals the lowest DAC code at which the comparator input is high, with the comparator taken as a level that is 1 when the DAC level is at or above the input.
- R5: If the comparator stays low through the all-ones code, the result is all-ones and overrange is 1. Otherwise overrange is 0.
- R6: Done is high for exactly one cycle, C+3 clock edges after the start edge for a result C. Busy stays high from the start edge until that edge and falls on it.
- R7: The result and overrange outputs change only on the edge that raises done.
- R8: A start request while busy is ignored: the ramp continues and the done timing and result are unchanged.
- R9: After done, the DAC code equals the result until the next accepted start.
- R10: A comparator level left high from the previous conversion does not end the next conversion early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request, sampled each cycle |
| cmp_i | input | 1 | Asynchronous comparator level, high when the DAC level is at or above the input |
| dac_code_o | output | CODE_W | Code driven to the external DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | CODE_W | Last converted code |
| overrange_o | output | 1 | Last conversion ran past full scale without a trip |

## Verification
The bench builds the block with a 5-bit code and a two-stage synchroniser. With these values a full ramp lasts only 34 cycles, so every input level from zero to past full scale is swept directly, and overrange comes up often. Random levels, with start requests fired at random points in the ramp, run alongside directed cases. The directed cases cover a trip exactly at the all-ones code and a low level following a high one, where the comparator is still high at the start.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RAMP = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic clr;
        logic gate;
        logic load;
    } cnt_ctl_t;

    function automatic int unsigned full_scale(input int unsigned width);
        return (32'd1 << width) - 32'd1;
    endfunction

endpackage

// File: rtl/ramp_sync.sv
module ramp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst || clr) pipe <= '0;
                else            pipe <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst || clr) pipe <= '0;
                else            pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ramp_count.sv
module ramp_count
    import ramp_adc_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int CNT_W  = CODE_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_ctl_t          ctl,
    input  logic [CODE_W-1:0] load_val,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int HI_W = CNT_W - CODE_W;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (ctl.load) cnt_q <= {{HI_W{1'b0}}, load_val};
        else if (ctl.clr)  cnt_q <= '0;
        else if (ctl.gate) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign code_o = (|cnt_q[CNT_W-1:CODE_W]) ? '1 : cnt_q[CODE_W-1:0];

    // R3
    ramp_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.gate && !ctl.load && !ctl.clr) |=> (code_o >= $past(code_o)));
endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
    import ramp_adc_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int CNT_W  = CODE_W + 2,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              trip_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output cnt_ctl_t          ctl,
    output logic [CODE_W-1:0] load_val,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] result_o,
    output logic              over_o
);
    localparam int unsigned      FS      = full_scale(CODE_W);
    localparam logic [CNT_W-1:0] END_CNT = CNT_W'(FS + SYNC);

    seq_state_e        state;
    logic              accept;
    logic              finish;
    logic [CODE_W-1:0] back_code;
    logic [CODE_W-1:0] fin_code;

    assign accept    = (state == ST_IDLE) && start_i;
    assign finish    = (state == ST_RAMP) && (trip_i || (cnt_i == END_CNT));
    assign back_code = CODE_W'(cnt_i - CNT_W'(SYNC));
    assign fin_code  = trip_i ? back_code : CODE_W'(FS);

    always_comb begin
        ctl.clr  = accept;
        ctl.gate = (state == ST_RAMP) && !finish;
        ctl.load = finish;
    end

    assign load_val = fin_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done_o   <= 1'b0;
            result_o <= '0;
            over_o   <= 1'b0;
        end else begin
            done_o <= finish;
            if (accept) state <= ST_RAMP;
            if (finish) begin
                state    <= ST_IDLE;
                result_o <= fin_code;
                over_o   <= !trip_i;
            end
        end
    end

    assign busy_o = (state == ST_RAMP);

    // R10
    no_early_trip_chk: assert property (@(posedge clk) disable iff (rst)
        (trip_i && state == ST_RAMP) |-> (cnt_i >= CNT_W'(SYNC)));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (result_o != $past(result_o)) |-> done_o);

    // R7
    over_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (over_o != $past(over_o)) |-> done_o);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RAMP && !finish && start_i) |=> (busy_o && cnt_i != '0));
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
    import ramp_adc_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cmp_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] result_o,
    output logic              overrange_o
);
    localparam int CNT_W = CODE_W + 2;

    cnt_ctl_t          ctl;
    logic              trip;
    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] load_val;

    ramp_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .clr (ctl.clr),
        .d   (cmp_i),
        .q   (trip)
    );

    ramp_count #(.CODE_W(CODE_W), .CNT_W(CNT_W)) i_count (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .load_val (load_val),
        .cnt_o    (cnt),
        .code_o   (dac_code_o)
    );

    ramp_seq #(.CODE_W(CODE_W), .CNT_W(CNT_W), .SYNC(SYNC_STAGES)) i_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .trip_i   (trip),
        .cnt_i    (cnt),
        .ctl      (ctl),
        .load_val (load_val),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .result_o (result_o),
        .over_o   (overrange_o)
    );

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && dac_code_o == '0));

    // R3
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |->
        (dac_code_o == $past(dac_code_o) || dac_code_o == $past(dac_code_o) + 1'b1));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R5
    over_full_chk: assert property (@(posedge clk) disable iff (rst)
        overrange_o |-> (result_o == '1));

    // R9
    dac_rests_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (dac_code_o == result_o));
endmodule

// File: tb/test_ramp_adc_ctrl.sv
module test_ramp_adc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 5;
    localparam int MAXC       = (1 << CODE_W) - 1;
    localparam int WATCHDOG   = 50000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              cmp_i;
    logic [CODE_W-1:0] dac_code_o;
    logic              busy_o;
    logic              done_o;
    logic [CODE_W-1:0] result_o;
    logic              overrange_o;

    int lvl = 0;
    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural comparator: DAC level at or above the held input
    assign cmp_i = (int'(dac_code_o) >= lvl);

    ramp_adc_ctrl #(.CODE_W(CODE_W), .SYNC_STAGES(2)) i_ramp_adc_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .cmp_i       (cmp_i),
        .dac_code_o  (dac_code_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .result_o    (result_o),
        .overrange_o (overrange_o)
    );

    function automatic int exp_code(input int level);
        return (level > MAXC) ? MAXC : level;
    endfunction

    function automatic int exp_over(input int level);
        return (level > MAXC) ? 1 : 0;
    endfunction

    function automatic int ramp_at(input int j);
        return (j > MAXC) ? MAXC : j;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_conv(input int level, input int poke);
        int code;
        int prev_res;
        int prev_over;
        string tag;
        code      = exp_code(level);
        prev_res  = int'(result_o);
        prev_over = int'(overrange_o);
        tag       = (poke > 0) ? "R8" : "R4";
        lvl       = level;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2 busy", int'(busy_o), 1);
        check(dac_code_o == '0, "R2 dac", int'(dac_code_o), 0);
        for (int j = 1; j <= code + 4; j++) begin
            @(negedge clk);
            if (poke > 0 && j == poke)     start_i = 1'b1;
            if (poke > 0 && j == poke + 1) start_i = 1'b0;
            if (j < code + 3) begin
                check(int'(dac_code_o) == ramp_at(j), "R3 ramp", int'(dac_code_o), ramp_at(j));
                check(busy_o && !done_o, "R6 busy", int'({busy_o, done_o}), 2);
                check(int'(result_o) == prev_res && int'(overrange_o) == prev_over,
                      "R7 hold", int'(result_o), prev_res);
            end else if (j == code + 3) begin
                check(done_o && !busy_o, {tag, " done"}, int'({busy_o, done_o}), 1);
                check(int'(result_o) == code, {tag, " result"}, int'(result_o), code);
                check(int'(overrange_o) == exp_over(level), "R5 over", int'(overrange_o), exp_over(level));
                check(int'(dac_code_o) == code, "R9 dac", int'(dac_code_o), code);
            end else begin
                check(!done_o && !busy_o, "R6 pulse", int'({busy_o, done_o}), 0);
                check(int'(dac_code_o) == code, "R9 rest", int'(dac_code_o), code);
            end
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4417));
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !overrange_o, "R1 flags",
              int'({busy_o, done_o, overrange_o}), 0);
        check(result_o == '0 && dac_code_o == '0, "R1 codes", int'(result_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && dac_code_o == '0, "R1 after", int'(dac_code_o), 0);

        // directed corners
        run_conv(0, 0);
        run_conv(1, 0);
        run_conv(2, 0);
        run_conv(MAXC - 1, 0);
        run_conv(MAXC, 0);
        run_conv(MAXC + 1, 0);
        run_conv(MAXC + 5, 0);
        run_conv(MAXC + 5, 0);
        run_conv(0, 0);          // R10: comparator still high from previous code
        run_conv(MAXC, 0);
        run_conv(3, 0);          // R10
        run_conv(7, 1);
        run_conv(12, 14);
        run_conv(MAXC + 2, 20);

        // exhaustive sweep
        for (int v = 0; v <= MAXC + 2; v++) run_conv(v, 0);

        // random levels and stray starts
        for (int k = 0; k < 60; k++) begin
            int level;
            int poke;
            level = int'($urandom_range(MAXC + 3, 0));
            poke  = ($urandom_range(1, 0) == 1) ? int'($urandom_range(exp_code(level) + 2, 1)) : 0;
            run_conv(level, poke);
            repeat (int'($urandom_range(2, 0))) @(negedge clk);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule